// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Sequencer

This block is the device-side controller of a byte-wide parallel EEPROM, modelled synchronously on a fast system clock. It watches the active-low chip-enable, output-enable and write-enable strobes together with the address and data buses. A write strobe latches one byte into a page buffer. Every further byte of the burst must belong to the same page and must arrive inside a load window. When the strobes stay idle for long enough, the buffer is committed. A timed programming phase then copies the loaded bytes into a register-array memory.

The block counts as busy from the first loaded byte until programming ends. While it is busy, a read returns a polling status rather than memory contents. Each strobe passes through a synchronizer and a pulse filter, so short noise pulses cannot start a write.

Every timing threshold is given in microseconds or nanoseconds and turned into clock cycles through a clock-frequency parameter. A bench can therefore shrink them. With `ADDR_W` set to 15 the array holds 32768 bytes. The default build uses a smaller array.

Top module: `eep_page_writer`

## Requirements
- R1: The low 6 address bits select the byte offset within a 64-byte page. The remaining upper bits select the page. A byte written at offset 63 of a page reads back from that same address.
- R2: A byte is loaded when `ce_n` and `we_n` are both low while `oe_n` is high. The address is taken when the later of the two goes low, and the data when the first of the two returns high.
- R3: A burst loads from 1 to 64 bytes. When the same offset is loaded twice in one burst, the later data is what gets stored.
- R4: Inside a burst, a byte whose page field differs from the page of the burst's first byte is dropped. The location it addressed keeps its old contents.
- R5: A byte that completes more than `LOAD_WIN_US` after the previous accepted byte is dropped.
- R6: `busy` rises with the first accepted byte. The buffer is committed once `ce_n` or `we_n` has stayed high for `IDLE_US`. `busy` then stays high for exactly `PROG_US` of programming.
- R7: A read while `busy` is high drives the inverse of bit 7 of the last accepted byte on `dout[7]`, with `dout[6:0]` at zero.
- R8: Once programming ends, a read returns the stored byte with its true bit 7.
- R9: `dout_en` is high only in read mode: `ce_n` low, `oe_n` low and `we_n` high. In every other strobe state, and after reset, it is low.
- R10: A strobe low pulse of `GLITCH_NS` or less (one 20 ns cycle at 50 MHz) is ignored and starts no write. A two-cycle pulse is accepted.
- R11: If `oe_n` is low at any point while `ce_n` and `we_n` are both low, no byte is loaded.
- R12: Write strobes that occur during programming are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in the low 6 bits |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | High when the data bus would be driven |
| busy | output | 1 | High from the first loaded byte until programming ends |

## Verification
A pre-fill burst of one byte leaves known contents in one page. A multi-byte burst then loads that page again, repeats one offset, and includes a byte aimed at a foreign page. Reads of both pages afterwards show whether the page filter and the last-write-wins rule act on the right bytes. Polling reads taken during loading and during programming tell the last-accepted-byte bit apart from the bit of a dropped byte. Separate strobe patterns then exercise the rejection paths one at a time: a late byte, a write issued during programming, a write with output enable low, a write with output enable dropped mid-strobe, and a one-cycle strobe pulse. Each is paired with an accepted case, a two-cycle pulse or a byte inside the window, so that a design which rejects everything is still caught.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and time-to-cycle helpers for the EEPROM
// write sequencer. Assumes integer microsecond/nanosecond timing inputs.
package eep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_t;

    // Cycles covering a span given in microseconds.
    function automatic int us_to_cyc(input int mhz, input int us);
        return mhz * us;
    endfunction

    // Consecutive cycles a strobe must hold a new level before it is believed:
    // one more than the number of cycles a rejected pulse may last.
    function automatic int glitch_cyc(input int mhz, input int ns);
        return (mhz * ns) / 1000 + 1;
    endfunction

endpackage

// File: rtl/eep_strobe_filter.sv
`timescale 1ns/1ps
// Module: eep_strobe_filter
// Synchronizes one active-low strobe and passes a new level only after it
// has been stable for FILT_CYC consecutive cycles, which removes short
// noise pulses. Assumes the strobe is idle (high) out of reset.
module eep_strobe_filter #(
    parameter int FILT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic clean_n
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic             sync1_q, sync2_q;
    logic [CNT_W-1:0] run_q;

    // Two-stage synchronizer onto clk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= raw_n;
            sync2_q <= sync1_q;
        end
    end

    // Stability counter: adopt the new level after FILT_CYC matching cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_n <= 1'b1;
            run_q   <= '0;
        end else if (sync2_q != clean_n) begin
            if (run_q == CNT_W'(FILT_CYC - 1)) begin
                clean_n <= sync2_q;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

endmodule

// File: rtl/eep_page_buffer.sv
`timescale 1ns/1ps
// Module: eep_page_buffer
// Holds one page of pending bytes plus a per-offset loaded flag. A clear
// with a simultaneous write starts a new burst holding only that byte.
// Assumes reads during copy-out use the registered contents.
module eep_page_buffer #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;
    logic [PAGE_BYTES-1:0] hit;

    assign hit = PAGE_BYTES'(1) << wr_off;

    // Byte storage; newer data at an offset replaces older data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_off] <= wr_data;
        end
    end

    // Loaded flags: cleared per burst, set per written offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (clear) begin
            loaded_q <= wr_en ? hit : '0;
        end else if (wr_en) begin
            loaded_q <= loaded_q | hit;
        end
    end

    assign rd_data  = slot_q[rd_off];
    assign rd_valid = loaded_q[rd_off];

endmodule

// File: rtl/eep_prog_ctrl.sv
`timescale 1ns/1ps
// Module: eep_prog_ctrl
// Turns filtered strobes into byte-load events. Runs the load-window and
// idle timers, commits the page and sequences the programming phase, which
// copies the buffer out one offset per cycle. Assumes PROG_CYC exceeds the
// page size and that address and data are stable around each strobe.
module eep_prog_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int OFF_W    = 6,
    parameter int DATA_W   = 8,
    parameter int WIN_CYC  = 1500,
    parameter int IDLE_CYC = 5000,
    parameter int PROG_CYC = 500000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_f,
    input  logic                    oe_f,
    input  logic                    we_f,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       din,
    output logic                    buf_clear,
    output logic                    buf_wr,
    output logic [OFF_W-1:0]        buf_off,
    output logic [DATA_W-1:0]       buf_data,
    output logic [OFF_W-1:0]        copy_off,
    output logic                    copy_en,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic                    busy,
    output logic                    prog_phase,
    output logic                    poll_bit
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int IDLE_W = $clog2(IDLE_CYC + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    eep_state_t        state_q;
    logic              strobe_on, strobe_q, armed_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [WIN_W-1:0]  win_cnt_q;
    logic [IDLE_W-1:0] idle_cnt_q;
    logic [PROG_W-1:0] prog_cnt_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  copy_off_q;
    logic              copy_done_q, poll_q;
    logic              load_ev, same_page, win_open, accept, commit;

    // Write strobe is the overlap of chip enable and write enable.
    assign strobe_on = !ce_f && !we_f;

    // Strobe edge tracking: address at strobe start, arm only with OE high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q   <= 1'b0;
            armed_q    <= 1'b0;
            lat_addr_q <= '0;
        end else begin
            strobe_q <= strobe_on;
            if (strobe_on && !strobe_q) begin
                armed_q    <= oe_f;
                lat_addr_q <= addr;
            end else if (!strobe_on || !oe_f) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Acceptance and commit decisions for the current cycle.
    always_comb begin
        load_ev   = strobe_q && !strobe_on && armed_q && oe_f;
        same_page = (lat_addr_q[ADDR_W-1:OFF_W] == page_q);
        win_open  = (win_cnt_q < WIN_W'(WIN_CYC));
        accept    = load_ev && ((state_q == ST_IDLE) ||
                    ((state_q == ST_LOAD) && win_open && same_page));
        commit    = (state_q == ST_LOAD) && !strobe_on &&
                    (idle_cnt_q == IDLE_W'(IDLE_CYC - 1));
    end

    // Sequencer: idle, burst loading, timed programming with copy-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            win_cnt_q   <= '0;
            idle_cnt_q  <= '0;
            prog_cnt_q  <= '0;
            page_q      <= '0;
            copy_off_q  <= '0;
            copy_done_q <= 1'b0;
            poll_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q    <= ST_LOAD;
                        page_q     <= lat_addr_q[ADDR_W-1:OFF_W];
                        win_cnt_q  <= '0;
                        idle_cnt_q <= '0;
                        poll_q     <= din[DATA_W-1];
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        win_cnt_q <= '0;
                        poll_q    <= din[DATA_W-1];
                    end else if (win_cnt_q != WIN_W'(WIN_CYC)) begin
                        win_cnt_q <= win_cnt_q + 1'b1;
                    end
                    if (strobe_on) begin
                        idle_cnt_q <= '0;
                    end else if (commit) begin
                        state_q     <= ST_PROG;
                        prog_cnt_q  <= '0;
                        copy_off_q  <= '0;
                        copy_done_q <= 1'b0;
                    end else begin
                        idle_cnt_q <= idle_cnt_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    prog_cnt_q <= prog_cnt_q + 1'b1;
                    if (!copy_done_q) begin
                        if (copy_off_q == '1) begin
                            copy_done_q <= 1'b1;
                        end else begin
                            copy_off_q <= copy_off_q + 1'b1;
                        end
                    end
                    if (prog_cnt_q == PROG_W'(PROG_CYC - 1)) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign buf_clear  = (state_q == ST_IDLE) && load_ev;
    assign buf_wr     = accept;
    assign buf_off    = lat_addr_q[OFF_W-1:0];
    assign buf_data   = din;
    assign copy_off   = copy_off_q;
    assign copy_en    = (state_q == ST_PROG) && !copy_done_q;
    assign page       = page_q;
    assign busy       = (state_q != ST_IDLE);
    assign prog_phase = (state_q == ST_PROG);
    assign poll_bit   = poll_q;

endmodule

// File: rtl/eep_page_writer.sv
`timescale 1ns/1ps
// Module: eep_page_writer (top)
// Byte-wide EEPROM device logic: filtered strobes, a page-buffered write
// sequencer, a register-array memory and a read mux that shows polling
// status while busy. Assumes a synchronous clock much faster than the
// strobes, and address and data held stable around each strobe.
module eep_page_writer
    import eep_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int LOAD_WIN_US = 30,
    parameter int IDLE_US     = 100,
    parameter int PROG_US     = 10000,
    parameter int GLITCH_NS   = 20,
    parameter int ADDR_W      = 11,
    parameter int OFF_W       = 6,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int WIN_CYC  = us_to_cyc(CLK_MHZ, LOAD_WIN_US);
    localparam int IDLE_CYC = us_to_cyc(CLK_MHZ, IDLE_US);
    localparam int PROG_CYC = us_to_cyc(CLK_MHZ, PROG_US);
    localparam int FILT_CYC = glitch_cyc(CLK_MHZ, GLITCH_NS);
    localparam int N_STROBE = 3;

    logic [N_STROBE-1:0] raw_n, clean_n;
    logic                ce_f, oe_f, we_f;
    logic                buf_clear, buf_wr, copy_en, prog_phase, poll_bit;
    logic                buf_valid, mem_we;
    logic [OFF_W-1:0]    buf_off, copy_off;
    logic [DATA_W-1:0]   buf_data, buf_rd, rd_q;
    logic [PAGE_W-1:0]   page;
    logic [DATA_W-1:0]   array_q [DEPTH];

    assign raw_n = {ce_n, oe_n, we_n};

    // One noise filter per control strobe.
    for (genvar gi = 0; gi < N_STROBE; gi++) begin : g_filt
        eep_strobe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_n  (raw_n[gi]),
            .clean_n(clean_n[gi])
        );
    end

    assign ce_f = clean_n[2];
    assign oe_f = clean_n[1];
    assign we_f = clean_n[0];

    eep_prog_ctrl #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .DATA_W  (DATA_W),
        .WIN_CYC (WIN_CYC),
        .IDLE_CYC(IDLE_CYC),
        .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_f      (ce_f),
        .oe_f      (oe_f),
        .we_f      (we_f),
        .addr      (addr),
        .din       (din),
        .buf_clear (buf_clear),
        .buf_wr    (buf_wr),
        .buf_off   (buf_off),
        .buf_data  (buf_data),
        .copy_off  (copy_off),
        .copy_en   (copy_en),
        .page      (page),
        .busy      (busy),
        .prog_phase(prog_phase),
        .poll_bit  (poll_bit)
    );

    eep_page_buffer #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (buf_wr),
        .wr_off  (buf_off),
        .wr_data (buf_data),
        .rd_off  (copy_off),
        .rd_data (buf_rd),
        .rd_valid(buf_valid)
    );

    assign mem_we = copy_en && buf_valid;

    // Memory array: copy-out writes and a registered read port.
    always_ff @(posedge clk) begin
        if (mem_we) begin
            array_q[{page, copy_off}] <= buf_rd;
        end
        rd_q <= array_q[addr];
    end

    // Output mux: polling status while busy, stored data otherwise.
    always_comb begin
        dout_en = !ce_f && !oe_f && we_f;
        dout    = busy ? {~poll_bit, {(DATA_W-1){1'b0}}} : rd_q;
    end

endmodule

// File: rtl/eep_page_writer_chk.sv
`timescale 1ns/1ps
// Module: eep_page_writer_chk
// Timing and protocol checks for eep_page_writer, attached by bind.
// Assumes the same PROG_CYC as the bound instance.
module eep_page_writer_chk #(
    parameter int PROG_CYC = 500000,
    parameter int PAGE_W   = 5,
    parameter int DATA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              prog_phase,
    input logic              buf_wr,
    input logic              mem_we,
    input logic              dout_en,
    input logic [DATA_W-1:0] dout,
    input logic [PAGE_W-1:0] page
);
    int unsigned prog_len;

    // Length of the current programming phase in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_len <= 0;
        end else if (prog_phase) begin
            prog_len <= prog_len + 1;
        end else begin
            prog_len <= 0;
        end
    end

    a_r6_prog_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_phase) |-> (prog_len == PROG_CYC));

    a_r6_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_wr));

    a_r12_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        prog_phase |-> !buf_wr);

    a_r8_copy_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> prog_phase);

    a_r4_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page));

    a_r7_poll_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dout_en) |-> (dout[DATA_W-2:0] == '0));

    a_r2_one_load_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> !buf_wr);

endmodule

bind eep_page_writer eep_page_writer_chk #(
    .PROG_CYC(PROG_CYC),
    .PAGE_W  (PAGE_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .prog_phase(prog_phase),
    .buf_wr    (buf_wr),
    .mem_we    (mem_we),
    .dout_en   (dout_en),
    .dout      (dout),
    .page      (page)
);

// File: tb/sim_eep_page_writer.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Driver tasks push expected items; a monitor on
// the falling clock edge pops and compares them against the outputs.
module sim_eep_page_writer;
    localparam int AW = 11;

    typedef struct packed {
        logic [7:0] d;
        logic       en;
        logic       bz;
        logic       chk_d;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #10 clk = ~clk;

    eep_page_writer #(
        .CLK_MHZ(50), .LOAD_WIN_US(1), .IDLE_US(2), .PROG_US(6),
        .GLITCH_NS(20), .ADDR_W(AW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    // Monitor: compare outputs with the oldest expected item.
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (dout_en !== e.en || busy !== e.bz || (e.chk_d && dout !== e.d)) begin
                fails++;
                $display("FAIL %s: dout=%h dout_en=%b busy=%b expected dout=%h dout_en=%b busy=%b",
                         t, dout, dout_en, busy, e.d, e.en, e.bz);
            end
        end
    end

    function automatic logic [AW-1:0] at(input int pg, input int off);
        return {5'(pg), 6'(off)};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_now(input logic [7:0] d, input logic en, input logic bz,
                              input logic chk_d, input string t);
        exp_q.push_back('{d: d, en: en, bz: bz, chk_d: chk_d});
        tag_q.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; din = d; oe_n = 1'b1;
        ce_n = 1'b0; we_n = 1'b0;
        tick(6);
        ce_n = 1'b1; we_n = 1'b1;
        tick(6);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic bz, input string t);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        tick(6);
        expect_now(d, 1'b1, bz, 1'b1, t);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(6);
    endtask

    task automatic status(input logic bz, input string t);
        expect_now(8'h00, 1'b0, bz, 1'b0, t);
    endtask

    task automatic wait_done(input string t);
        int n = 0;
        while (busy !== 1'b0 && n < 2000) begin
            tick(1);
            n++;
        end
        checks++;
        if (busy !== 1'b0) begin
            fails++;
            $display("FAIL %s: busy=%b expected busy=0", t, busy);
        end
        tick(4);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(8);
        status(1'b0, "R9 reset: bus released, not busy");

        // Pre-fill: single-byte burst on page 3.
        wr(at(3, 5), 8'h91);
        status(1'b1, "R6 busy after first byte");
        wait_done("R6 single-byte burst completes");
        rd(at(3, 5), 8'h91, 1'b0, "R3 one-byte burst / R8 true bit 7");

        // Multi-byte burst on page 2 with a repeat and a foreign-page byte.
        wr(at(2, 0), 8'h01);
        wr(at(2, 1), 8'h5A);
        wr(at(2, 1), 8'h6B);
        wr(at(2, 63), 8'h43);
        wr(at(3, 5), 8'h99);
        rd(at(2, 0), 8'h80, 1'b1, "R7 poll during load uses last accepted byte");
        tick(211);
        rd(at(2, 0), 8'h80, 1'b1, "R7 poll during programming");
        wr(at(2, 0), 8'hEE);
        tick(113);
        status(1'b1, "R6 still programming before commit+program time");
        tick(60);
        status(1'b0, "R6 programming finished on time");
        rd(at(2, 0), 8'h01, 1'b0, "R12 write during programming ignored");
        rd(at(2, 1), 8'h6B, 1'b0, "R3 newer data at repeated offset");
        rd(at(2, 63), 8'h43, 1'b0, "R1 offset 63 of page 2");
        rd(at(3, 5), 8'h91, 1'b0, "R4 foreign-page byte dropped");

        // Load window: second byte arrives too late.
        wr(at(4, 0), 8'h10);
        tick(70);
        wr(at(4, 0), 8'h77);
        wait_done("R5 burst with late byte completes");
        rd(at(4, 0), 8'h10, 1'b0, "R5 late byte dropped");

        // Write inhibit: OE low throughout the strobe.
        addr = at(3, 5); din = 8'hEE;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        tick(6);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(20);
        status(1'b0, "R11 OE low blocks write");
        // OE drops in the middle of the strobe.
        ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        oe_n = 1'b0;
        tick(4);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(20);
        status(1'b0, "R11 OE low mid-strobe blocks write");
        rd(at(3, 5), 8'h91, 1'b0, "R11 data unchanged");

        // One-cycle strobe pulse is noise.
        ce_n = 1'b0; we_n = 1'b0;
        tick(1);
        ce_n = 1'b1; we_n = 1'b1;
        tick(20);
        status(1'b0, "R10 one-cycle pulse ignored");
        rd(at(3, 5), 8'h91, 1'b0, "R10 data unchanged after pulse");

        // Two-cycle pulse is a real write.
        addr = at(5, 0); din = 8'h3C;
        ce_n = 1'b0; we_n = 1'b0;
        tick(2);
        ce_n = 1'b1; we_n = 1'b1;
        tick(10);
        status(1'b1, "R10 two-cycle pulse accepted");
        wait_done("R10 two-cycle burst completes");
        rd(at(5, 0), 8'h3C, 1'b0, "R10 two-cycle pulse data stored");

        // Bus enable in non-read strobe states.
        ce_n = 1'b0;
        tick(6);
        status(1'b0, "R9 CE low with OE high: bus released");
        ce_n = 1'b1; oe_n = 1'b0;
        tick(6);
        status(1'b0, "R9 CE high: bus released");
        oe_n = 1'b1;
        tick(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule